// File: doc/BRIEF.md
# Single-Slope Potentiometer Timing Converter

This block is the digital side of a single-slope converter that reads a resistive potentiometer wired to an external RC network. It runs a continuous frame of 512 clocks. During the first half of each frame it closes an external switch that empties the capacitor. During the second half it releases the capacitor and counts clocks until an external comparator reports that the capacitor voltage has crossed half the supply. A larger resistance charges the capacitor more slowly, so it gives a larger count. There is one charging slope toward a fixed threshold and no de-integration phase.

The comparator output passes through a two-flop synchronizer. Within the measurement half, the first cycle in which the synchronized comparator reads high latches the low 8 bits of the frame counter. At the frame boundary the result register loads either the latched count or, if the comparator never tripped, the saturated value 255. A one-cycle valid strobe marks each update, so a reader never sees a partial count. Calibration and linearisation of the resistance are left to the consumer of the result.

Top module: `pot_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, discharge_en is 1, result is 0 and result_valid is 0. The frame counter restarts at the beginning of the discharge half.
- R2: Each frame is 512 cycles. discharge_en is 1 for the first 256 cycles and 0 for the last 256, and the pattern repeats with no gap.
- R3: result_valid is high for exactly one cycle, in the first cycle of each frame that follows a completed frame (cycle 512·n after reset release, n ≥ 1), and is low otherwise. result changes only in a cycle where result_valid is high.
- R4: If cmp_in is first high in measurement cycle k (k counts from 0 at the first cycle with discharge_en low) and is low from the end of the discharge half until then, the next strobe reports k+2. The two cycles come from the synchronizer.
- R5: If the synchronized comparator already reads high in the first measurement cycle, the result is 0. cmp_in high from measurement cycle −1 onward gives 1.
- R6: If the synchronized comparator never reads high during the measurement half, the result is 255. This is the case for a first high at k ≥ 254.
- R7: Only the first synchronized high in a measurement half counts. A one-cycle pulse at cycle k1 followed by a later rise gives k1+2.
- R8: cmp_in activity that reaches the synchronizer output only during the discharge half has no effect. Pulses that end before measurement cycle −2 leave the result at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, about 1 MHz |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator output, high when the capacitor is above half supply (asynchronous) |
| discharge_en | output | 1 | Closes the external discharge switch when high |
| result | output | 8 | Last completed conversion count |
| result_valid | output | 1 | One-cycle strobe when result is updated |

## Verification
The bench sweeps the comparator's first rising cycle over every measurement position from 0 to 255. This checks the linear k+2 mapping and the point where the mapping turns into saturation at 254. Rises placed before the measurement half show whether a comparator that is already high reads as 0 (or 1), rather than as a stale count. A short pulse followed by a later rise shows whether the first trip is held. A pulse that falls away inside the discharge half shows whether discharge-time activity leaks into the count. A reset in the middle of a measurement half checks that the frame restarts cleanly and that the first strobe after reset is correctly delayed.

// File: rtl/pot_timer.sv
module pot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic             discharge_en,
  output logic [CNT_W-1:0] result,
  output logic             result_valid
);
  localparam int FRM_W = CNT_W + 1;

  logic [FRM_W-1:0] frame_q;
  logic             sync1_q, sync2_q;
  logic             tripped_q;
  logic [CNT_W-1:0] capt_q;

  wire measure   = frame_q[CNT_W];
  wire frame_end = &frame_q;
  wire trip      = measure & sync2_q & ~tripped_q;

  assign discharge_en = ~measure;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q      <= '0;
      sync1_q      <= 1'b0;
      sync2_q      <= 1'b0;
      tripped_q    <= 1'b0;
      capt_q       <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      frame_q      <= frame_q + 1'b1;
      sync1_q      <= cmp_in;
      sync2_q      <= sync1_q;
      result_valid <= 1'b0;
      if (trip) begin
        tripped_q <= 1'b1;
        capt_q    <= frame_q[CNT_W-1:0];
      end
      if (frame_end) begin
        result       <= tripped_q ? capt_q : '1;
        result_valid <= 1'b1;
        tripped_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pot_timer_chk.sv
module pot_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             discharge_en,
  input logic [CNT_W-1:0] result,
  input logic             result_valid
);
  localparam int HALF = 1 << CNT_W;

  logic [CNT_W:0] dis_run_q;

  always_ff @(posedge clk) begin
    if (rst) dis_run_q <= '0;
    else if (discharge_en) dis_run_q <= dis_run_q + 1'b1;
    else dis_run_q <= '0;
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_result_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));

  assert_strobe_at_frame_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(discharge_en) |-> result_valid);

  assert_no_strobe_mid_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(discharge_en) |-> !result_valid);

  assert_discharge_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(discharge_en) |-> (dis_run_q == (CNT_W+1)'(HALF)));
endmodule

bind pot_timer pot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .discharge_en(discharge_en),
  .result(result),
  .result_valid(result_valid)
);

// File: tb/pot_timer_tb.sv
module pot_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 512;
  localparam int HALF = 256;
  localparam int NEVER = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in = 1'b0;
  logic       discharge_en;
  logic [7:0] result;
  logic       result_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  int prev_exp = 0;
  string prev_tag = "";

  pot_timer u_dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in),
    .discharge_en(discharge_en), .result(result), .result_valid(result_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int i, input int lo1, input int hi1, input int lo2);
    return (i >= lo1 && i < hi1) || (i >= lo2);
  endfunction

  function automatic int expect_of(input int lo1, input int hi1, input int lo2);
    for (int t = HALF; t < FRAME; t++)
      if (pat(t - 2, lo1, hi1, lo2)) return t - HALF;
    return 255;
  endfunction

  task automatic strobe_check();
    if (have_prev) begin
      chk(result_valid == 1'b1, {prev_tag, " R3 strobe"}, result_valid, 1);
      chk(result == 8'(prev_exp), {prev_tag, " result"}, result, prev_exp);
    end else begin
      chk(result_valid == 1'b0, "R1 no strobe", result_valid, 0);
      chk(result == 8'd0, "R1 result zero", result, 0);
      chk(discharge_en == 1'b1, "R1 discharge", discharge_en, 1);
    end
  endtask

  task automatic run_frame(input int lo1, input int hi1, input int lo2, input string tag);
    for (int i = 0; i < FRAME; i++) begin
      if (i == 0) strobe_check();
      if (i == 1) chk(result_valid == 1'b0, "R3 one cycle", result_valid, 0);
      if (i == 255) chk(discharge_en == 1'b1, "R2 discharge end", discharge_en, 1);
      if (i == 256) chk(discharge_en == 1'b0, "R2 measure start", discharge_en, 0);
      if (i == 511) chk(discharge_en == 1'b0, "R2 measure end", discharge_en, 0);
      if (i == 300 && have_prev)
        chk(result == 8'(prev_exp), "R3 result held", result, prev_exp);
      cmp_in = pat(i, lo1, hi1, lo2);
      @(negedge clk);
    end
    have_prev = 1'b1;
    prev_exp = expect_of(lo1, hi1, lo2);
    prev_tag = tag;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(discharge_en == 1'b1, "R1 discharge in reset", discharge_en, 1);
    chk(result == 8'd0, "R1 result in reset", result, 0);
    chk(result_valid == 1'b0, "R1 valid in reset", result_valid, 0);
    rst = 1'b0;

    run_frame(0, NEVER, NEVER, "R5 high whole frame");
    run_frame(HALF - 3, NEVER, NEVER, "R5 early k=-3");
    run_frame(HALF - 2, NEVER, NEVER, "R5 early k=-2");
    run_frame(HALF - 1, NEVER, NEVER, "R5 early k=-1");
    for (int k = 0; k < 256; k++)
      run_frame(HALF + k, NEVER, NEVER, (k >= 254) ? "R6 saturate" : "R4 sweep");
    run_frame(300, 301, 400, "R7 first trip held");
    run_frame(HALF + 250, HALF + 251, HALF + 252, "R7 pulse then rise");
    run_frame(0, 254, NEVER, "R8 discharge activity");
    run_frame(10, 200, NEVER, "R8 early pulse");

    strobe_check();
    for (int i = 0; i < 300; i++) begin
      cmp_in = 1'b0;
      @(negedge clk);
    end
    chk(discharge_en == 1'b0, "R2 mid measure", discharge_en, 0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(discharge_en == 1'b1, "R1 mid reset discharge", discharge_en, 1);
    chk(result == 8'd0, "R1 mid reset result", result, 0);
    chk(result_valid == 1'b0, "R1 mid reset valid", result_valid, 0);
    rst = 1'b0;
    have_prev = 1'b0;
    run_frame(HALF + 10, NEVER, NEVER, "R4 after reset");
    run_frame(NEVER, NEVER, NEVER, "R6 never trips");
    strobe_check();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule